// File: doc/BRIEF.md
# Up-Counting Timer with One Compare Output Channel

This block combines a 16-bit up-counter and one compare output channel. The counter runs while the `run` input is high. It counts from 0 up to an auto-reload value, returns to 0 and signals an update event on each wrap. The channel compares the count with an active compare value. From that result it forms a reference level in one of four modes: frozen, toggle on match, PWM mode 1 or PWM mode 2. The reference goes through a polarity inverter and an output gate to the pin.

Software writes five registers through a single write port. The compare value and the auto-reload value each have their own preload enable. When a preload enable is clear, a write takes effect at once. When it is set, the write is held and reaches the active register only at the next update event. Software can also force an update event. A compare match sets a sticky flag, and the flag drives an interrupt request when interrupts are enabled.

Write map (`wr_addr`):

| Address | Register | Bits written |
|---|---|---|
| 0 | configuration | [2:0] mode, [3] compare preload enable, [4] polarity, [5] output enable, [6] interrupt enable, [7] reload preload enable |
| 1 | auto-reload value | [15:0] |
| 2 | compare value | [15:0] |
| 3 | flag | [0] = 0 clears the match flag; 1 has no effect |
| 4 | event | [0] = 1 forces an update event |

Top module: `tmr_chan_top`

## Requirements
- R1: While `run` is 1 and no update is forced, `count` rises by one each clock until it reaches the auto-reload value. While `run` is 0, `count` holds.
- R2: With `run` at 1, a count at or above the active auto-reload value returns to 0 on the next clock. That wrap is an update event.
- R3: A write to address 1 replaces the active auto-reload value on the next clock when configuration bit 7 is 0. When bit 7 is 1, the value is held and becomes active only on the clock of the next update event.
- R4: A write to address 2 behaves the same way, gated by configuration bit 3. The active compare value changes immediately when the bit is 0, or at the next update event when it is 1.
- R5: Writing address 4 with bit 0 set clears `count` to 0 and makes both held values active on the next clock. This happens even while `run` is 0.
- R6: In mode 3'b011, the reference inverts on the clock after `count` equals the active compare value while `run` is 1. An update event does not change it.
- R7: In mode 3'b110 (PWM mode 1), the reference is 1 exactly while `count` is below the active compare value. It is 1 for the whole period if the compare value exceeds the auto-reload value, and always 0 if the compare value is 0.
- R8: In mode 3'b111 (PWM mode 2), the reference is the inverse of its PWM mode 1 value.
- R9: In mode 3'b000, and in every other unlisted code, the reference holds its last toggle-mode level.
- R10: `out_pin` equals the reference XOR configuration bit 4 while configuration bit 5 is 1, and is 0 while bit 5 is 0.
- R11: `cc_flag` becomes 1 on the clock after a match, whatever the interrupt enable. Writing 0 to bit 0 of address 3 clears it. A write of 1 does nothing, and a match in the same cycle as a clear wins.
- R12: `irq` is 1 exactly while `cc_flag` and configuration bit 6 are both 1.
- R13: After reset, `count`, `out_pin`, `cc_flag` and `irq` are 0. The configuration is 0, the compare value is 0 and the auto-reload value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| out_pin | output | 1 | Channel output pin |
| cc_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench first runs directed stretches, one per mode. PWM mode 1 runs with compare values inside the period, above the auto-reload value and at zero, which separates the `<` test from a `<=` test and from wrap handling. Toggle and frozen runs mixed with forced updates show whether an update event disturbs the held reference. Preload runs write a value mid-period and then wait, which separates a direct write from a write held until the update event. A long seeded random mix of writes to every address, with small periods, then stresses same-cycle collisions such as a write during a wrap, a match during a flag clear, and a mode change during a match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [2:0] ADDR_CFG    = 3'd0;
    localparam logic [2:0] ADDR_RELOAD = 3'd1;
    localparam logic [2:0] ADDR_CMP    = 3'd2;
    localparam logic [2:0] ADDR_FLAG   = 3'd3;
    localparam logic [2:0] ADDR_EVENT  = 3'd4;

    localparam logic [2:0] MODE_FROZEN = 3'b000;
    localparam logic [2:0] MODE_TOGGLE = 3'b011;
    localparam logic [2:0] MODE_PWM1   = 3'b110;
    localparam logic [2:0] MODE_PWM2   = 3'b111;

    typedef struct packed {
        logic       reload_pe;
        logic       irq_en;
        logic       out_en;
        logic       pol;
        logic       cmp_pe;
        logic [2:0] mode;
    } chan_cfg_t;

    // Reference level from mode, "count below compare" and the toggle state
    function automatic logic ref_level(input logic [2:0] mode,
                                       input logic below,
                                       input logic tog);
        case (mode)
            MODE_PWM1: ref_level = below;
            MODE_PWM2: ref_level = ~below;
            default:   ref_level = tog;
        endcase
    endfunction

endpackage

// File: rtl/tmr_shadow_reg.sv
module tmr_shadow_reg #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         pre_en,
    input  logic         uev,
    output logic [W-1:0] active
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= RST_VAL;
            active <= RST_VAL;
        end else begin
            if (wr) held_q <= wdata;
            if (wr && !pre_en) active <= wdata;
            else if (uev)      active <= held_q;
        end
    end

    // R3 R4
    // preload_hold_chk
    preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_en && !uev) |=> $stable(active));

    // R3 R4
    // direct_write_chk
    direct_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !pre_en) |=> (active == $past(wdata)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         force_upd,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = run && (cnt >= reload);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (force_upd) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else if (run)       cnt <= cnt + 1'b1;
    end

    // R1
    // cnt_step_chk
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !force_upd && cnt < reload) |=> (cnt == $past(cnt) + 1'b1));

    // R1
    // cnt_hold_chk
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !force_upd) |=> $stable(cnt));

    // R2 R5
    // cnt_zero_chk
    cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap || force_upd) |=> (cnt == '0));
endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  chan_cfg_t    cfg,
    input  logic         flag_clr,
    output logic         pin,
    output logic         flag,
    output logic         irq
);
    logic match;
    logic tog_q;
    logic ref_lvl;

    assign match   = run && (cnt == cmp);
    assign ref_lvl = ref_level(cfg.mode, cnt < cmp, tog_q);
    assign pin     = cfg.out_en ? (ref_lvl ^ cfg.pol) : 1'b0;
    assign irq     = flag && cfg.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            if (match && cfg.mode == MODE_TOGGLE) tog_q <= ~tog_q;
            if (match)         flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    // R11
    // match_flag_chk
    match_flag_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> flag);

    // R6
    // toggle_flip_chk
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (match && cfg.mode == MODE_TOGGLE) |=> (tog_q != $past(tog_q)));

    // R6 R9
    // toggle_hold_chk
    toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(match && cfg.mode == MODE_TOGGLE) |=> $stable(tog_q));

    // R11
    // flag_keep_chk
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             out_pin,
    output logic             cc_flag,
    output logic             irq
);
    localparam int CFG_W = $bits(chan_cfg_t);
    localparam logic [CNT_W-1:0] RELOAD_RST = '1;

    chan_cfg_t        cfg_q;
    logic             wr_reload, wr_cmp, force_upd, flag_clr;
    logic             wrap, uev;
    logic [CNT_W-1:0] reload_act, cmp_act;

    assign wr_reload = wr_en && wr_addr == ADDR_RELOAD;
    assign wr_cmp    = wr_en && wr_addr == ADDR_CMP;
    assign force_upd = wr_en && wr_addr == ADDR_EVENT && wr_data[0];
    assign flag_clr  = wr_en && wr_addr == ADDR_FLAG && !wr_data[0];
    assign uev       = wrap || force_upd;

    always_ff @(posedge clk) begin
        if (rst)                               cfg_q <= '0;
        else if (wr_en && wr_addr == ADDR_CFG) cfg_q <= chan_cfg_t'(wr_data[CFG_W-1:0]);
    end

    tmr_shadow_reg #(.W(CNT_W), .RST_VAL(RELOAD_RST)) u_reload (
        .clk(clk), .rst(rst), .wr(wr_reload), .wdata(wr_data),
        .pre_en(cfg_q.reload_pe), .uev(uev), .active(reload_act)
    );

    tmr_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_cmp (
        .clk(clk), .rst(rst), .wr(wr_cmp), .wdata(wr_data),
        .pre_en(cfg_q.cmp_pe), .uev(uev), .active(cmp_act)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .force_upd(force_upd),
        .reload(reload_act), .cnt(count), .wrap(wrap)
    );

    tmr_chan_out #(.W(CNT_W)) u_out (
        .clk(clk), .rst(rst), .run(run), .cnt(count), .cmp(cmp_act),
        .cfg(cfg_q), .flag_clr(flag_clr), .pin(out_pin), .flag(cc_flag), .irq(irq)
    );

    // R10
    // pin_gate_chk
    pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.out_en |-> !out_pin);

    // R12
    // irq_flag_chk
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> cc_flag);
endmodule

// File: tb/tmr_chan_top_test.sv
`timescale 1ns/1ps
module tmr_chan_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        out_pin, cc_flag, irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string phase = "R13 reset";

    // reference model state
    logic [15:0] m_cnt, m_arr, m_arrp, m_cmp, m_cmpp;
    logic [7:0]  m_cfg;
    logic        m_tog, m_flag;

    always #2.5 clk = ~clk;

    tmr_chan_top uut (
        .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .out_pin(out_pin),
        .cc_flag(cc_flag), .irq(irq)
    );

    function automatic logic exp_ref();
        case (m_cfg[2:0])
            3'b110:  return m_cnt < m_cmp;
            3'b111:  return !(m_cnt < m_cmp);
            default: return m_tog;
        endcase
    endfunction

    function automatic logic exp_pin();
        return m_cfg[5] ? (exp_ref() ^ m_cfg[4]) : 1'b0;
    endfunction

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL [%s] %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_arr = '1; m_arrp = '1; m_cmp = '0; m_cmpp = '0;
        m_cfg = '0; m_tog = 1'b0; m_flag = 1'b0;
    endtask

    // one clock with given inputs; model advances, outputs checked at negedge
    task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] d, input logic r);
        logic ug, wrap, uev, match, clr;
        logic [15:0] n_cnt, n_arr, n_arrp, n_cmp, n_cmpp;
        logic [7:0] n_cfg;
        logic n_tog, n_flag;
        wr_en = we; wr_addr = a; wr_data = d; run = r;
        ug    = we && a == 3'd4 && d[0];
        clr   = we && a == 3'd3 && !d[0];
        wrap  = r && (m_cnt >= m_arr);
        uev   = wrap || ug;
        match = r && (m_cnt == m_cmp);
        n_cnt = ug ? 16'd0 : (wrap ? 16'd0 : (r ? m_cnt + 16'd1 : m_cnt));
        n_arrp = (we && a == 3'd1) ? d : m_arrp;
        n_arr  = (we && a == 3'd1 && !m_cfg[7]) ? d : (uev ? m_arrp : m_arr);
        n_cmpp = (we && a == 3'd2) ? d : m_cmpp;
        n_cmp  = (we && a == 3'd2 && !m_cfg[3]) ? d : (uev ? m_cmpp : m_cmp);
        n_cfg  = (we && a == 3'd0) ? d[7:0] : m_cfg;
        n_tog  = (match && m_cfg[2:0] == 3'b011) ? ~m_tog : m_tog;
        n_flag = match ? 1'b1 : (clr ? 1'b0 : m_flag);
        @(posedge clk);
        m_cnt = n_cnt; m_arr = n_arr; m_arrp = n_arrp; m_cmp = n_cmp;
        m_cmpp = n_cmpp; m_cfg = n_cfg; m_tog = n_tog; m_flag = n_flag;
        @(negedge clk);
        wr_en = 1'b0;
        chk("count (R1 R2 R5)", count, m_cnt);
        chk("out_pin (R10)", {15'd0, out_pin}, {15'd0, exp_pin()});
        chk("cc_flag (R11)", {15'd0, cc_flag}, {15'd0, m_flag});
        chk("irq (R12)", {15'd0, irq}, {15'd0, m_flag & m_cfg[6]});
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 1'b1);
    endtask

    task automatic idle(input int n, input logic r);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 16'd0, r);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL [watchdog] run did not finish actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R13 reset state
        chk("count R13", count, 16'd0);
        chk("out_pin R13", {15'd0, out_pin}, 16'd0);
        chk("cc_flag R13", {15'd0, cc_flag}, 16'd0);
        chk("irq R13", {15'd0, irq}, 16'd0);

        phase = "R1 counting"; idle(6, 1'b1);
        phase = "R5 force update"; cyc(1'b1, 3'd4, 16'd1, 1'b0);
        phase = "R1 hold"; idle(4, 1'b0);
        phase = "R3 reload direct"; wr(3'd0, 16'h0026); wr(3'd1, 16'd9);
        phase = "R2 wrap"; idle(25, 1'b1);
        phase = "R7 pwm1 inside"; wr(3'd2, 16'd4); idle(25, 1'b1);
        phase = "R7 cmp above reload"; wr(3'd2, 16'd12); idle(12, 1'b1);
        phase = "R7 cmp zero"; wr(3'd2, 16'd0); idle(12, 1'b1);
        phase = "R8 pwm2"; wr(3'd2, 16'd5); wr(3'd0, 16'h0027); idle(12, 1'b1);
        phase = "R10 polarity"; wr(3'd0, 16'h0037); idle(12, 1'b1);
        phase = "R10 output off"; wr(3'd0, 16'h0017); idle(12, 1'b1);
        phase = "R4 compare preload"; wr(3'd0, 16'h002E); wr(3'd2, 16'd7); idle(15, 1'b1);
        phase = "R3 reload preload"; wr(3'd0, 16'h00AE); wr(3'd1, 16'd5); idle(25, 1'b1);
        phase = "R6 toggle"; wr(3'd0, 16'h002B); wr(3'd2, 16'd3);
        cyc(1'b1, 3'd4, 16'd1, 1'b1); idle(30, 1'b1);
        phase = "R12 irq enable"; wr(3'd0, 16'h0063); idle(10, 1'b1);
        phase = "R11 flag clear"; wr(3'd3, 16'd0); idle(2, 1'b1);
        wr(3'd3, 16'd1); idle(2, 1'b0); cyc(1'b1, 3'd3, 16'd0, 1'b0); idle(2, 1'b0);
        phase = "R9 frozen"; wr(3'd0, 16'h0020); idle(20, 1'b1);
        cyc(1'b1, 3'd4, 16'd1, 1'b1); idle(5, 1'b1);

        phase = "random mix";
        for (int i = 0; i < 6000; i++) begin
            logic we;
            logic [2:0] a;
            logic [15:0] d;
            logic r;
            we = ($urandom % 4) == 0;
            a  = 3'($urandom % 5);
            r  = ($urandom % 8) != 0;
            case (a)
                3'd0: begin
                    d = 16'($urandom % 256);
                    case ($urandom % 5)
                        0: d[2:0] = 3'b000;
                        1: d[2:0] = 3'b011;
                        2: d[2:0] = 3'b110;
                        3: d[2:0] = 3'b111;
                        default: ;
                    endcase
                end
                3'd1: d = 16'($urandom % 16);
                3'd2: d = 16'($urandom % 19);
                3'd4: d = 16'(($urandom % 6) == 0);
                default: d = 16'($urandom % 2);
            endcase
            cyc(we, a, d, r);
        end
        summary();
    end
endmodule